// File: doc/BRIEF.md
# L2 Cache-Control Operation Router

This block sits between the first-level data cache and the second-level cache controller. It receives cache-control and ordering operations, one per accepted handshake. For each one it decides what the second-level cache and the system bus must do. The operations are conditional store, block flush, block store, block invalidate, instruction-block invalidate, global and local block zero, sync, eieio and first-level block push. The decision uses:
- the lookup results: first-level hit, second-level hit and sector dirty;
- the write-through mode of each level;
- whether the store reservation is still live;
- a broadcast-enable bit.

The decision is given as one-cycle action strobes in the cycle after acceptance. When an operation needs the bus, the block refuses new operations until the bus acknowledges. Tag lookup, data storage and the bus protocol are handled elsewhere.

Top module: `l2_ctl_op_router`

## Requirements
- R1: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its strobes are high for exactly the next cycle. In any other cycle every strobe is 0. After reset every strobe is 0, and `in_ready` is 1 once the reset release has passed through the synchroniser.
- R2: Conditional store (code 0) with a second-level miss or a reservation that is no longer live asserts only forward-to-bus.
- R3: Conditional store (code 0) that hits the second level with the reservation live asserts write-L2 and done. This applies when the sector is dirty, or when both levels hit and neither level is in write-through mode.
- R4: Conditional store (code 0) that hits the second level with the reservation live, but meets neither condition of R3, asserts forward-to-bus and invalidate-L2.
- R5: First-level block push (code 9) asserts forward-to-bus. It also asserts invalidate-L2 when the second level hits.
- R6: Block flush (code 1) asserts invalidate-L2 on a second-level hit and push-L2 on a dirty hit. When no push results, it asserts broadcast exactly when broadcast-enable is 1.
- R7: Block store (code 2) asserts push-L2 on a dirty second-level hit and never invalidates. Otherwise it asserts broadcast exactly when broadcast-enable is 1.
- R8: Block invalidate (code 3) asserts invalidate-L2 on a second-level hit. It also asserts broadcast when broadcast-enable is 1.
- R9: Instruction-block invalidate (code 4) produces no strobe at all.
- R10: Global block zero (code 5) asserts forward-to-bus on a second-level miss and clear-L1 with done when both levels hit. A hit in the second level only gives no strobe. Local block zero (code 6) asserts clear-L1 and done whatever the lookup flags are.
- R11: Sync (code 7) and eieio (code 8) assert only forward-to-bus.
- R12: Codes 10 to 15 assert only the bad-op flag, with no action strobe and no stall.
- R13: When a strobe cycle carries push-L2, forward-to-bus or broadcast, `in_ready` is 0 from that cycle on. It stays 0 until the cycle after a clock edge at which `bus_ack` is 1. `bus_ack` is sampled from the strobe cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Router can take an operation |
| in_op | input | 4 | Operation code |
| l1_hit | input | 1 | First-level lookup hit |
| l2_hit | input | 1 | Second-level lookup hit |
| l2_dirty | input | 1 | Hit sector is modified |
| l1_wthru | input | 1 | First level in write-through mode |
| l2_wthru | input | 1 | Second level in write-through mode |
| resv_live | input | 1 | Store reservation still held |
| bcast_en | input | 1 | Address-only broadcast enabled |
| bus_ack | input | 1 | Bus took the pending request |
| o_wr_l2 | output | 1 | Write the second-level sector |
| o_inv_l2 | output | 1 | Invalidate the second-level sector |
| o_push_l2 | output | 1 | Push the sector to the bus |
| o_fwd_bus | output | 1 | Forward the operation to the bus |
| o_bcast | output | 1 | Address-only bus broadcast |
| o_clr_l1 | output | 1 | Clear the first-level block |
| o_done | output | 1 | Operation completes locally |
| o_bad_op | output | 1 | Unrecognised operation code |

## Verification
Two things can fall in the same cycle. The first is the strobe cycle of a bus-bound operation. The second is the bus acknowledge that releases the stall, including an acknowledge that arrives in the strobe cycle itself. The bench drives `bus_ack` at random in every cycle, including strobe cycles. A behavioural model tracks the pending bus state, and `in_ready` is compared with it each cycle. Back-to-back acceptance of an operation during the previous operation's strobe cycle is also covered. All 16 codes are swept against all 128 flag combinations, and each cycle's strobes are checked against the model.

// File: rtl/l2r_pkg.sv
package l2r_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_STCX    = 4'd0,
    OP_FLUSH   = 4'd1,
    OP_STBLK   = 4'd2,
    OP_BINV    = 4'd3,
    OP_IINV    = 4'd4,
    OP_ZERO_G  = 4'd5,
    OP_ZERO_L  = 4'd6,
    OP_SYNC    = 4'd7,
    OP_EIEIO   = 4'd8,
    OP_L1PUSH  = 4'd9
  } op_e;

  typedef struct packed {
    logic wr_l2;
    logic inv_l2;
    logic push_l2;
    logic fwd_bus;
    logic bcast;
    logic clr_l1;
    logic done;
  } act_t;

  typedef struct packed {
    logic l1_hit;
    logic l2_hit;
    logic l2_dirty;
    logic l1_wt;
    logic l2_wt;
    logic resv;
    logic bcast_en;
  } cond_t;
endpackage

// File: rtl/l2r_rst_sync.sv
module l2r_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sh_q;
  logic [TOP:0] sh_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb sh_d = {sh_q[TOP-1:0], 1'b1};
    end else begin : g_single
      always_comb sh_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[TOP];
endmodule

// File: rtl/l2r_decide.sv
module l2r_decide
  import l2r_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  cond_t           c,
  output act_t            act,
  output logic            bad
);
  logic dirty_hit;
  logic copyback_both;

  assign dirty_hit     = c.l2_hit & c.l2_dirty;
  assign copyback_both = c.l1_hit & ~c.l1_wt & ~c.l2_wt;

  always_comb begin
    act = '0;
    bad = 1'b0;
    case (op)
      OP_STCX: begin
        if (!c.l2_hit || !c.resv) begin
          act.fwd_bus = 1'b1;
        end else if (c.l2_dirty || copyback_both) begin
          act.wr_l2 = 1'b1;
          act.done  = 1'b1;
        end else begin
          act.fwd_bus = 1'b1;
          act.inv_l2  = 1'b1;
        end
      end
      OP_FLUSH: begin
        act.inv_l2 = c.l2_hit;
        if (dirty_hit) act.push_l2 = 1'b1;
        else           act.bcast   = c.bcast_en;
      end
      OP_STBLK: begin
        if (dirty_hit) act.push_l2 = 1'b1;
        else           act.bcast   = c.bcast_en;
      end
      OP_BINV: begin
        act.inv_l2 = c.l2_hit;
        act.bcast  = c.bcast_en;
      end
      OP_IINV: begin
        act = '0;
      end
      OP_ZERO_G: begin
        if (!c.l2_hit) begin
          act.fwd_bus = 1'b1;
        end else if (c.l1_hit) begin
          act.clr_l1 = 1'b1;
          act.done   = 1'b1;
        end
      end
      OP_ZERO_L: begin
        act.clr_l1 = 1'b1;
        act.done   = 1'b1;
      end
      OP_SYNC, OP_EIEIO: begin
        act.fwd_bus = 1'b1;
      end
      OP_L1PUSH: begin
        act.fwd_bus = 1'b1;
        act.inv_l2  = c.l2_hit;
      end
      default: begin
        bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/l2r_stage.sv
module l2r_stage
  import l2r_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  act_t act_d,
  input  logic bad_d,
  input  logic bus_ack,
  output act_t act_q,
  output logic bad_q,
  output logic busy_q
);
  act_t act_n;
  logic bad_n;
  logic busy_n;
  logic busy_en;
  logic needs_bus;

  assign needs_bus = act_d.push_l2 | act_d.fwd_bus | act_d.bcast;

  always_comb begin
    act_n   = take ? act_d : '0;
    bad_n   = take & bad_d;
    busy_en = take | bus_ack;
    busy_n  = take ? needs_bus : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      bad_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      act_q <= act_n;
      bad_q <= bad_n;
      if (busy_en) busy_q <= busy_n;
    end
  end
endmodule

// File: rtl/l2_ctl_op_router.sv
module l2_ctl_op_router
  import l2r_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic            l1_hit,
  input  logic            l2_hit,
  input  logic            l2_dirty,
  input  logic            l1_wthru,
  input  logic            l2_wthru,
  input  logic            resv_live,
  input  logic            bcast_en,
  input  logic            bus_ack,
  output logic            o_wr_l2,
  output logic            o_inv_l2,
  output logic            o_push_l2,
  output logic            o_fwd_bus,
  output logic            o_bcast,
  output logic            o_clr_l1,
  output logic            o_done,
  output logic            o_bad_op
);
  logic  srst_n;
  logic  take;
  logic  busy_q;
  logic  bad_d;
  logic  bad_q;
  cond_t cond;
  act_t  act_d;
  act_t  act_q;

  l2r_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (srst_n)
  );

  assign cond = '{l1_hit:   l1_hit,
                  l2_hit:   l2_hit,
                  l2_dirty: l2_dirty,
                  l1_wt:    l1_wthru,
                  l2_wt:    l2_wthru,
                  resv:     resv_live,
                  bcast_en: bcast_en};

  l2r_decide i_dec (
    .op  (in_op),
    .c   (cond),
    .act (act_d),
    .bad (bad_d)
  );

  assign in_ready = srst_n & ~busy_q;
  assign take     = in_valid & in_ready;

  l2r_stage i_stg (
    .clk     (clk),
    .rst_n   (srst_n),
    .take    (take),
    .act_d   (act_d),
    .bad_d   (bad_d),
    .bus_ack (bus_ack),
    .act_q   (act_q),
    .bad_q   (bad_q),
    .busy_q  (busy_q)
  );

  assign o_wr_l2   = act_q.wr_l2;
  assign o_inv_l2  = act_q.inv_l2;
  assign o_push_l2 = act_q.push_l2;
  assign o_fwd_bus = act_q.fwd_bus;
  assign o_bcast   = act_q.bcast;
  assign o_clr_l1  = act_q.clr_l1;
  assign o_done    = act_q.done;
  assign o_bad_op  = bad_q;
endmodule

// File: rtl/l2r_checker.sv
module l2r_checker
  import l2r_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OP_W-1:0] in_op,
  input logic            l2_hit,
  input logic            resv_live,
  input logic            bus_ack,
  input logic            o_wr_l2,
  input logic            o_inv_l2,
  input logic            o_push_l2,
  input logic            o_fwd_bus,
  input logic            o_bcast,
  input logic            o_clr_l1,
  input logic            o_done,
  input logic            o_bad_op
);
  logic any_act;
  logic bus_act;
  logic acc;

  assign any_act = o_wr_l2 | o_inv_l2 | o_push_l2 | o_fwd_bus | o_bcast | o_clr_l1 | o_done;
  assign bus_act = o_push_l2 | o_fwd_bus | o_bcast;
  assign acc     = in_valid & in_ready;

  a_r1_strobe_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (any_act || o_bad_op) |-> $past(acc));

  a_r3_write_needs_reservation: assert property (@(posedge clk) disable iff (!rst_n)
    o_wr_l2 |-> ($past(resv_live && l2_hit) && o_done && !o_fwd_bus));

  a_r7_store_block_keeps_sector: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_STBLK) |=> !o_inv_l2);

  a_r9_iinv_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_IINV) |=> (!any_act && !o_bad_op));

  a_r12_bad_op_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    o_bad_op |-> !any_act);

  a_r13_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && !bus_ack) |=> !in_ready);

  a_r13_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && bus_ack) |=> in_ready);
endmodule

bind l2_ctl_op_router l2r_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .l2_hit    (l2_hit),
  .resv_live (resv_live),
  .bus_ack   (bus_ack),
  .o_wr_l2   (o_wr_l2),
  .o_inv_l2  (o_inv_l2),
  .o_push_l2 (o_push_l2),
  .o_fwd_bus (o_fwd_bus),
  .o_bcast   (o_bcast),
  .o_clr_l1  (o_clr_l1),
  .o_done    (o_done),
  .o_bad_op  (o_bad_op)
);

// File: tb/test_l2_ctl_op_router.sv
module test_l2_ctl_op_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = 4'd0;
  logic       l1_hit = 1'b0, l2_hit = 1'b0, l2_dirty = 1'b0;
  logic       l1_wthru = 1'b0, l2_wthru = 1'b0, resv_live = 1'b0, bcast_en = 1'b0;
  logic       bus_ack = 1'b0;
  logic       o_wr_l2, o_inv_l2, o_push_l2, o_fwd_bus, o_bcast, o_clr_l1, o_done, o_bad_op;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit model_ready = 0;
  bit model_busy = 0;
  bit last_acc = 0;

  always #10 clk = ~clk;

  l2_ctl_op_router i_l2_ctl_op_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .l2_dirty(l2_dirty), .l1_wthru(l1_wthru),
    .l2_wthru(l2_wthru), .resv_live(resv_live), .bcast_en(bcast_en), .bus_ack(bus_ack),
    .o_wr_l2(o_wr_l2), .o_inv_l2(o_inv_l2), .o_push_l2(o_push_l2), .o_fwd_bus(o_fwd_bus),
    .o_bcast(o_bcast), .o_clr_l1(o_clr_l1), .o_done(o_done), .o_bad_op(o_bad_op)
  );

  // Expected result as {bad, wr, inv, push, fwd, bcast, clr, done}
  function automatic logic [7:0] expect_of(int op, bit a1, bit a2, bit dt, bit w1, bit w2,
                                           bit rv, bit be);
    bit wr = 0, inv = 0, push = 0, fwd = 0, bc = 0, clr = 0, dn = 0, bad = 0;
    if (op == 0) begin                       // R2 R3 R4
      if (!a2 || !rv) fwd = 1;
      else if (dt || (a1 && !w1 && !w2)) begin wr = 1; dn = 1; end
      else begin fwd = 1; inv = 1; end
    end else if (op == 9) begin              // R5
      fwd = 1; inv = a2;
    end else if (op == 1) begin              // R6
      inv = a2; push = a2 && dt; bc = !push && be;
    end else if (op == 2) begin              // R7
      push = a2 && dt; bc = !push && be;
    end else if (op == 3) begin              // R8
      inv = a2; bc = be;
    end else if (op == 4) begin              // R9
    end else if (op == 5) begin              // R10
      if (!a2) fwd = 1;
      else if (a1) begin clr = 1; dn = 1; end
    end else if (op == 6) begin
      clr = 1; dn = 1;
    end else if (op == 7 || op == 8) begin   // R11
      fwd = 1;
    end else begin                           // R12
      bad = 1;
    end
    return {bad, wr, inv, push, fwd, bc, clr, dn};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R2/R3/R4";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      5, 6: return "R10";
      7, 8: return "R11";
      9: return "R5";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [7:0] outs();
    return {o_bad_op, o_wr_l2, o_inv_l2, o_push_l2, o_fwd_bus, o_bcast, o_clr_l1, o_done};
  endfunction

  // One negedge: model the edge just passed, compare, leave inputs for the caller.
  task automatic tick();
    logic [7:0] exp;
    string tag;
    @(negedge clk);
    last_acc = in_valid && model_ready;
    if (last_acc) begin
      exp = expect_of(int'(in_op), l1_hit, l2_hit, l2_dirty, l1_wthru, l2_wthru,
                      resv_live, bcast_en);
      tag = tag_of(int'(in_op));
      model_busy = exp[4] || exp[3] || exp[2];
    end else begin
      exp = 8'h00;
      tag = "R1";
      if (bus_ack) model_busy = 0;
    end
    model_ready = !model_busy;
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: strobes op=%0d got %b expected %b", tag, in_op, outs(), exp);
    end
    checks++;
    if (in_ready !== model_ready) begin
      errors++;
      $display("FAIL R13: in_ready got %b expected %b", in_ready, model_ready);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;                                     // R1 reset state
    if (outs() !== 8'h00 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: after reset got %b/%b expected 00000000/1", outs(), in_ready);
    end
    model_ready = 1;
    model_busy  = 0;

    // Sweep: every code against every flag combination
    for (int op = 0; op < 16; op++) begin
      for (int f = 0; f < 128; f++) begin
        in_valid = 1'b1;
        in_op = 4'(op);
        {l1_hit, l2_hit, l2_dirty, l1_wthru, l2_wthru, resv_live, bcast_en} = 7'(f);
        do begin
          bus_ack = 1'($urandom_range(0, 1));
          tick();
        end while (!last_acc);
        in_valid = 1'b0;
      end
    end

    // Random traffic with random valid and bus acknowledge
    for (int n = 0; n < 4000; n++) begin
      in_valid = 1'($urandom_range(0, 3) != 0);
      in_op = 4'($urandom_range(0, 15));
      {l1_hit, l2_hit, l2_dirty, l1_wthru, l2_wthru, resv_live, bcast_en} =
        7'($urandom_range(0, 127));
      bus_ack = 1'($urandom_range(0, 1));
      tick();
    end

    in_valid = 1'b0;
    bus_ack = 1'b1;
    repeat (3) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule